// File: doc/BRIEF.md
# Multimode Timer/Event Counter

A 16-bit up-counting peripheral that a processor programs through a byte-wide register bus. Depending on a two-bit mode field it counts ticks of an internal clock (an interval timer), transitions on an external input (an event counter), or internal ticks only while the external input holds a chosen level (a pulse-width counter). On reaching its maximum value the counter does not wrap to zero. It reloads from a programmable preload value and keeps counting. Each overflow produces a wake-up pulse, and also an interrupt request pulse when the interrupt enable input is high.

The internal tick comes either from the system clock enable divided by eight or from the falling edges of an alternate slow clock input. Software reads the 16-bit count as two bytes. Reading the high byte captures the low byte into a holding register, and a later low-byte read returns that captured value, so the two halves always belong to the same count. In event mode counting continues while the power-down input is high. In the two internally clocked modes the tick is stopped during power-down.

Top module: `tmr_evt_ctr`

## Requirements
- R1: Register addresses: 0 control, read/write; 1 preload low byte, read/write; 2 preload high byte, read/write; 3 held low byte, read; 4 live high byte, read. Any other address reads 0, and `bus_rdata` is 0 unless a read is selected. After reset the control, preload, counter and holding registers are 0 and `irq` and `wake` are low.
- R2: Control bit 4 is the run bit. With bit 4 at 0 the counter does not change, except through a preload write (R7).
- R3: Control bits 7:6 = 2'b01 select event mode. With control bit 3 at 0 each rising edge of `evt_pin` adds one. With bit 3 at 1 each falling edge adds one. Edges of the opposite direction are ignored.
- R4: Control bits 7:6 = 2'b10 select timer mode. With control bit 5 at 0 the counter advances once per 8 cycles in which `sys_ce` is high, and not at all while `sys_ce` stays low. With bit 5 at 1 it advances once per falling edge of `slow_clk`, after two synchronizing flops.
- R5: An increment from 16'hFFFF loads the current preload value in that same step, and counting continues from there.
- R6: An overflow raises `irq` for exactly one cycle, in the cycle the reloaded value appears, and only if `irq_en` was high at that clock edge.
- R7: A preload byte write while the run bit is 0 also writes the same byte of the counter. While the run bit is 1 it changes only the preload value, which is used at the next reload.
- R8: A read of address 4 copies the live counter low byte into the holding register at that clock edge. A read of address 3 returns the held value, not the live count.
- R9: With `pwr_down` high, event mode keeps counting, while timer and pulse-width modes do not advance. Every overflow pulses `wake` for one cycle, whatever the state of `irq_en`.
- R10: `evt_pin` passes through two flops before edge detection. A rising edge driven before clock edge N changes the counter at edge N+2, and the counter advances at most one step per clock.
- R11: Control bits 7:6 = 2'b11 select pulse-width mode. The counter advances on the internal tick only while `evt_pin` is high (control bit 3 = 0) or low (bit 3 = 1). When the pin leaves that level, the count holds and the run bit clears by itself.
- R12: Control bits 7:6 = 2'b00 disable counting, whatever the run bit and the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_ce | input | 1 | System clock enable, feeds the divide-by-8 tick |
| slow_clk | input | 1 | Alternate slow clock, sampled as a level |
| evt_pin | input | 1 | External event or gate input, asynchronous |
| pwr_down | input | 1 | Power-down state indication |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq_en | input | 1 | Overflow interrupt enable |
| irq | output | 1 | Overflow interrupt request pulse |
| wake | output | 1 | Overflow wake-up pulse |

## Verification
On every cycle the in-line properties check these points: a stopped counter holds its value; an overflow is followed by the preload value; an interrupt pulse never appears without the enable and always comes with a wake pulse; a high-byte read captures the previous low byte; a direct preload load lands in the counter; mode 00 never increments; and the synchronizer never reports a rise and a fall at once. The properties cannot show edge polarity selection, the divide-by-8 cadence, the two-flop pin latency, pulse-width termination at the pin's level change, or power-down behaviour per mode. The bench shows these through scenarios with known counts, and a behavioural model compares `irq`, `wake` and `bus_rdata` against the design on every clock.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  // control byte layout, msb first
  typedef struct packed {
    tmr_mode_e  mode;      // 7:6
    logic       alt_clk;   // 5 : 1 = slow clock tick, 0 = divided system tick
    logic       run;       // 4
    logic       neg_sel;   // 3 : falling edge / low level active
    logic [2:0] spare;     // 2:0
  } ctrl_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_PRE_LO = 3'd1;
  localparam logic [2:0] ADDR_PRE_HI = 3'd2;
  localparam logic [2:0] ADDR_CNT_LO = 3'd3;
  localparam logic [2:0] ADDR_CNT_HI = 3'd4;

endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;

  assert_one_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));

endmodule

// File: rtl/tmr_evt_tick.sv
module tmr_evt_tick #(
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_ce_i,
  input  logic slow_clk_i,
  input  logic alt_sel_i,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] PS_LAST = {DIV_W{1'b1}};

  logic [DIV_W-1:0] ps_q;
  logic             div_tick;
  logic             slow_lvl, slow_rise, slow_fall;

  always_ff @(posedge clk) begin
    if (!rst_n)        ps_q <= '0;
    else if (sys_ce_i) ps_q <= ps_q + 1'b1;
  end

  assign div_tick = sys_ce_i && (ps_q == PS_LAST);

  tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_slow_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (slow_clk_i),
    .level_o (slow_lvl),
    .rise_o  (slow_rise),
    .fall_o  (slow_fall)
  );

  assign tick_o = alt_sel_i ? slow_fall : div_tick;

  assert_div_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick);

endmodule

// File: rtl/tmr_evt_core.sv
module tmr_evt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             run_i,
  input  logic             irq_en_i,
  input  logic             pre_lo_wr_i,
  input  logic             pre_hi_wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pre_o,
  output logic [7:0]       hold_o,
  output logic             irq_o,
  output logic             wake_o,
  output logic             ovf_o
);
  localparam int               HI_W    = CNT_W - 8;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, pre_q;
  logic [7:0]       hold_q;
  logic             irq_q, wake_q;
  logic             ovf, direct_load;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (c == CNT_MAX) ? p : c + 1'b1;
  endfunction

  assign ovf         = inc_i && (cnt_q == CNT_MAX);
  assign direct_load = (pre_lo_wr_i || pre_hi_wr_i) && !run_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      hold_q <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= ovf && irq_en_i;
      wake_q <= ovf;
      if (cap_i) hold_q <= cnt_q[7:0];
      if (inc_i) cnt_q <= step_count(cnt_q, pre_q);
      if (pre_lo_wr_i) begin
        pre_q[7:0] <= wdata_i;
        if (!run_i) cnt_q[7:0] <= wdata_i;
      end
      if (pre_hi_wr_i) begin
        pre_q[CNT_W-1:8] <= HI_W'(wdata_i);
        if (!run_i) cnt_q[CNT_W-1:8] <= HI_W'(wdata_i);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign pre_o  = pre_q;
  assign hold_o = hold_q;
  assign irq_o  = irq_q;
  assign wake_o = wake_q;
  assign ovf_o  = ovf;

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !direct_load) |=> $stable(cnt_q));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == $past(pre_q)));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(irq_en_i));

  assert_wake_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> wake_q);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (hold_q == $past(cnt_q[7:0])));

  assert_direct_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_lo_wr_i && !run_i) |=> (cnt_q[7:0] == $past(wdata_i)));

endmodule

// File: rtl/tmr_evt_ctr.sv
module tmr_evt_ctr
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_ce,
  input  logic       slow_clk,
  input  logic       evt_pin,
  input  logic       pwr_down,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_en,
  output logic       irq,
  output logic       wake
);
  localparam int HI_W = CNT_W - 8;

  ctrl_t            ctrl_q;
  logic             ctrl_wr, pre_lo_wr, pre_hi_wr, hi_rd, rd_en;
  logic             pin_lvl, pin_rise, pin_fall;
  logic             int_tick, int_ok, pin_active, pin_edge;
  logic             src_evt, inc, pulse_end, ovf;
  logic [CNT_W-1:0] cnt, pre;
  logic [7:0]       hold;

  assign rd_en     = bus_sel && !bus_wr;
  assign ctrl_wr   = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign pre_lo_wr = bus_sel && bus_wr && (bus_addr == ADDR_PRE_LO);
  assign pre_hi_wr = bus_sel && bus_wr && (bus_addr == ADDR_PRE_HI);
  assign hi_rd     = rd_en && (bus_addr == ADDR_CNT_HI);

  tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (evt_pin),
    .level_o (pin_lvl),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  tmr_evt_tick #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_ce_i   (sys_ce),
    .slow_clk_i (slow_clk),
    .alt_sel_i  (ctrl_q.alt_clk),
    .tick_o     (int_tick)
  );

  assign int_ok     = int_tick && !pwr_down;
  assign pin_active = ctrl_q.neg_sel ? ~pin_lvl : pin_lvl;
  assign pin_edge   = ctrl_q.neg_sel ? pin_fall : pin_rise;

  always_comb begin
    unique case (ctrl_q.mode)
      MODE_EVENT: src_evt = pin_edge;
      MODE_TIMER: src_evt = int_ok;
      MODE_PULSE: src_evt = int_ok && pin_active;
      default:    src_evt = 1'b0;
    endcase
  end

  assign inc       = ctrl_q.run && src_evt;
  assign pulse_end = (ctrl_q.mode == MODE_PULSE) && ctrl_q.run &&
                     (ctrl_q.neg_sel ? pin_rise : pin_fall);

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q     <= '0;
    else if (ctrl_wr)   ctrl_q     <= ctrl_t'(bus_wdata);
    else if (pulse_end) ctrl_q.run <= 1'b0;
  end

  tmr_evt_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (inc),
    .run_i       (ctrl_q.run),
    .irq_en_i    (irq_en),
    .pre_lo_wr_i (pre_lo_wr),
    .pre_hi_wr_i (pre_hi_wr),
    .wdata_i     (bus_wdata),
    .cap_i       (hi_rd),
    .cnt_o       (cnt),
    .pre_o       (pre),
    .hold_o      (hold),
    .irq_o       (irq),
    .wake_o      (wake),
    .ovf_o       (ovf)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_en) begin
      case (bus_addr)
        ADDR_CTRL:   bus_rdata = 8'(ctrl_q);
        ADDR_PRE_LO: bus_rdata = pre[7:0];
        ADDR_PRE_HI: bus_rdata = 8'(pre[CNT_W-1:8]);
        ADDR_CNT_LO: bus_rdata = hold;
        ADDR_CNT_HI: bus_rdata = 8'(cnt[CNT_W-1:8]);
        default:     bus_rdata = 8'h00;
      endcase
    end
  end

  assert_pulse_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_end && !ctrl_wr) |=> !ctrl_q.run);

  assert_off_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mode == MODE_OFF) |-> !inc);

  assert_pd_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && (ctrl_q.mode == MODE_TIMER)) |-> !inc);

  assert_ovf_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> wake);

endmodule

// File: tb/tmr_evt_ctr_tb_top.sv
module tmr_evt_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_ce = 1'b1, slow_clk = 1'b0, evt_pin = 1'b0, pwr_down = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, irq_en = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, wake;

  int n_chk = 0, n_fail = 0, cyc = 0, irq_seen = 0, wake_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_evt_ctr dut_i (
    .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .slow_clk(slow_clk),
    .evt_pin(evt_pin), .pwr_down(pwr_down), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .irq(irq), .wake(wake)
  );

  // behavioural reference model
  logic [7:0]  m_ctrl = 0, m_buf = 0;
  logic [15:0] m_cnt = 0, m_pre = 0;
  logic        m_irq = 0, m_wake = 0;
  int          m_ps = 0;
  logic        m_s1 = 0, m_s2 = 0, m_sp = 0, m_c1 = 0, m_c2 = 0, m_cp = 0;

  always @(posedge clk) begin
    logic rise, fall, sfall, itick, act, ev, inc, full, run, neg;
    if (!rst_n) begin
      m_ctrl = 0; m_buf = 0; m_cnt = 0; m_pre = 0; m_irq = 0; m_wake = 0;
      m_ps = 0; m_s1 = 0; m_s2 = 0; m_sp = 0; m_c1 = 0; m_c2 = 0; m_cp = 0;
    end else begin
      run   = m_ctrl[4];
      neg   = m_ctrl[3];
      rise  = m_s2 && !m_sp;
      fall  = !m_s2 && m_sp;
      sfall = !m_c2 && m_cp;
      itick = m_ctrl[5] ? sfall : (sys_ce && m_ps == 7);
      act   = neg ? !m_s2 : m_s2;
      case (m_ctrl[7:6])
        2'b01:   ev = neg ? fall : rise;
        2'b10:   ev = itick && !pwr_down;
        2'b11:   ev = itick && act && !pwr_down;
        default: ev = 1'b0;
      endcase
      inc  = run && ev;
      full = (m_cnt == 16'hFFFF);
      m_irq  = inc && full && irq_en;
      m_wake = inc && full;
      if (bus_sel && !bus_wr && bus_addr == 3'd4) m_buf = m_cnt[7:0];
      if (inc) m_cnt = full ? m_pre : m_cnt + 16'd1;
      if (bus_sel && bus_wr && bus_addr == 3'd1) begin
        m_pre[7:0] = bus_wdata;
        if (!run) m_cnt[7:0] = bus_wdata;
      end
      if (bus_sel && bus_wr && bus_addr == 3'd2) begin
        m_pre[15:8] = bus_wdata;
        if (!run) m_cnt[15:8] = bus_wdata;
      end
      if (bus_sel && bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata;
      else if (m_ctrl[7:6] == 2'b11 && run && (neg ? rise : fall)) m_ctrl[4] = 1'b0;
      if (sys_ce) m_ps = (m_ps + 1) % 8;
      m_sp = m_s2; m_s2 = m_s1; m_s1 = evt_pin;
      m_cp = m_c2; m_c2 = m_c1; m_c1 = slow_clk;
    end
  end

  function automatic logic [7:0] model_rdata();
    if (!(bus_sel && !bus_wr)) return 8'h00;
    case (bus_addr)
      3'd0: return m_ctrl;
      3'd1: return m_pre[7:0];
      3'd2: return m_pre[15:8];
      3'd3: return m_buf;
      3'd4: return m_cnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && !done) begin
      if (irq) irq_seen++;
      if (wake) wake_seen++;
      chk("R6 per-cycle irq", irq, m_irq);
      chk("R9 per-cycle wake", wake, m_wake);
      chk("R1 per-cycle rdata", bus_rdata, model_rdata());
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'd4, h);
    rd(3'd3, l);
    v = {h, l};
  endtask

  task automatic pin_pulses(input int n);
    repeat (n) begin
      @(negedge clk) evt_pin = 1; idle(4);
      evt_pin = 0; idle(4);
    end
  endtask

  task automatic slow_pulses(input int n);
    repeat (n) begin
      @(negedge clk) slow_clk = 1; idle(4);
      slow_clk = 0; idle(4);
    end
  endtask

  initial begin
    logic [15:0] v, x, y;
    logic [7:0]  b;
    int          i0, w0;
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state and address map
    rd(3'd0, b); chk("R1 ctrl reset", b, 0);
    rd_cnt(v);   chk("R1 counter reset", v, 0);
    chk("R1 irq reset", irq, 0);
    rd(3'd7, b); chk("R1 unmapped read", b, 0);
    // R7 stopped preload write loads counter
    wr(3'd1, 8'hF0); wr(3'd2, 8'hFF);
    rd_cnt(v); chk("R7 direct load", v, 16'hFFF0);
    rd(3'd2, b); chk("R1 preload hi readback", b, 8'hFF);
    // R3 rising-edge events
    irq_en = 1;
    wr(3'd0, 8'h50);
    pin_pulses(5);
    rd_cnt(v); chk("R3 rising edges", v, 16'hFFF5);
    // R5 reload with R6 interrupt
    i0 = irq_seen;
    pin_pulses(11);
    rd_cnt(v); chk("R5 reload", v, 16'hFFF0);
    chk("R6 irq pulse count", irq_seen - i0, 1);
    // R6 disabled interrupt, R9 wake still pulses
    irq_en = 0; i0 = irq_seen; w0 = wake_seen;
    pin_pulses(16);
    rd_cnt(v); chk("R5 second reload", v, 16'hFFF0);
    chk("R6 irq suppressed", irq_seen - i0, 0);
    chk("R9 wake without enable", wake_seen - w0, 1);
    // R3 falling edges
    wr(3'd0, 8'h58);
    pin_pulses(3);
    rd_cnt(v); chk("R3 falling edges", v, 16'hFFF3);
    // R2 run bit clear
    wr(3'd0, 8'h48);
    pin_pulses(3);
    rd_cnt(v); chk("R2 frozen", v, 16'hFFF3);
    // R12 mode off
    wr(3'd0, 8'h10);
    pin_pulses(3);
    rd_cnt(v); chk("R12 mode off", v, 16'hFFF3);
    // R7 running preload write
    wr(3'd0, 8'h50);
    wr(3'd1, 8'h00);
    rd_cnt(v); chk("R7 running write keeps count", v, 16'hFFF3);
    rd(3'd1, b); chk("R7 preload updated", b, 8'h00);
    pin_pulses(13);
    rd_cnt(v); chk("R7 new preload on reload", v, 16'hFF00);
    // R9 power down: event counts, timer does not
    pwr_down = 1;
    pin_pulses(2);
    rd_cnt(v); chk("R9 event in power down", v, 16'hFF02);
    wr(3'd0, 8'h90);
    idle(40);
    wr(3'd0, 8'h80);
    rd_cnt(v); chk("R9 timer halted in power down", v, 16'hFF02);
    pwr_down = 0;
    // R4 divided timer
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    wr(3'd0, 8'h90);
    idle(80);
    wr(3'd0, 8'h80);
    rd_cnt(x);
    chk("R4 div8 rate", (x >= 9 && x <= 11), 1);
    sys_ce = 0;
    wr(3'd0, 8'h90);
    idle(40);
    wr(3'd0, 8'h80);
    sys_ce = 1;
    rd_cnt(v); chk("R4 no count without sys_ce", v, x);
    // R4 slow clock
    wr(3'd0, 8'hB0);
    slow_pulses(4);
    idle(4);
    wr(3'd0, 8'hA0);
    rd_cnt(y); chk("R4 slow clock edges", y, x + 4);
    // R8 coherent low byte
    rd(3'd4, b);
    wr(3'd0, 8'hB0);
    slow_pulses(2);
    idle(4);
    wr(3'd0, 8'hA0);
    rd(3'd3, b); chk("R8 held low byte", b, y[7:0]);
    rd_cnt(v); chk("R8 live after capture", v, y + 2);
    // R10 pin latency, counter at FFFF so the step shows on irq
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h50);
    irq_en = 1;
    idle(2);
    @(negedge clk) evt_pin = 1;
    @(posedge clk) #1 chk("R10 edge 1 no count", irq, 0);
    @(posedge clk) #1 chk("R10 edge 2 no count", irq, 0);
    @(posedge clk) #1 chk("R10 edge 3 count", irq, 1);
    @(negedge clk) evt_pin = 0;
    idle(4);
    irq_en = 0;
    // R11 pulse width, active high
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'hD0);
    @(negedge clk) evt_pin = 1;
    idle(40);
    evt_pin = 0;
    idle(6);
    rd(3'd0, b); chk("R11 run auto clear", b, 8'hC0);
    rd_cnt(x); chk("R11 width count", (x >= 4 && x <= 6), 1);
    pin_pulses(2);
    idle(20);
    rd_cnt(v); chk("R11 holds after end", v, x);
    idle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule